// File: doc/BRIEF.md
# Double-Buffered Four-Channel DMA Engine

This block moves blocks of 32-bit words from one memory region to another on up to four independent channels. Each channel has two register sets. The host sees the program set: source, destination and byte count. The engine works from a hidden active set. The host can write the next transfer into the program set and re-issue a start while the current transfer is still running. The engine then marks the channel as having a reload pending. When the active count runs out, it copies the program set into the active set by itself, with no gap and no host action. Only the end of the last queued transfer raises the sticky completion flag.

A round-robin scheduler visits the channels in turn and gives each one a single slot. In that slot a running channel either moves one burst of at most 2048 bytes, finishes or reloads, or is failed. A burst moves one word per cycle through a simple memory master with a combinational read port and a write strobe. For test use, a channel can be armed to fail on its next serviced slot, which raises a sticky error flag. It can also be armed, while idle, to swallow one completion indication.

Top module: `dbuf_dma_engine`

## Requirements
- R1: After reset, all run, pending, completion and error outputs are 0 and `memWrEn` is 0.
- R2: Writing the control register with bit 0 (start) set on an idle channel copies the program source, destination and count into the active set. From the next cycle the channel reports run=1 and pending=0.
- R3: A start on a running channel only sets pending=1 and leaves the active transfer untouched. Program registers may be rewritten while a transfer runs without changing the data it moves.
- R4: When a running channel is serviced with an active count of zero and pending set, the program set becomes the active set and pending clears. Run stays 1 and no completion is raised.
- R5: When a running channel is serviced with an active count of zero and pending clear, run clears. The completion bit sets unless the miss flag is armed; in that case the miss flag disarms instead.
- R6: Control bit 2 arms the miss flag to suppress exactly one completion, and only when the channel is idle. Writing it while the channel runs has no effect.
- R7: Each service slot of a running channel with a nonzero count moves min(count, 2048) bytes as consecutive words, one per cycle. Source and destination advance by that amount.
- R8: Channels are serviced in ascending index order with wrap-around, at most one burst per slot. Two busy channels therefore alternate bursts.
- R9: Control bit 3 arms a one-shot failure. On the channel's next serviced slot while running, run and pending clear, the error bit sets and no data moves. This takes precedence over bursts and completion.
- R10: Control bit 1 (halt) clears run and pending together. No further word of that channel is written and no completion is raised. Halt wins over a start in the same write.
- R11: Completion and error bits are sticky. They clear only when 1 is written to control bit 4 (completion) or bit 5 (error); a set in the same cycle wins.
- R12: The register select encodes 0 = source, 1 = destination, 2 = count, 3 = control. The low two bits of addresses and counts are ignored. A start with count 0 completes on its first slot without writing memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgCh | input | CH_W | Channel addressed by the write |
| cfgSel | input | 2 | Register select (R12) |
| cfgData | input | ADDR_W | Write data |
| memRdAddr | output | ADDR_W | Byte address of the word being read |
| memRdData | input | 32 | Read data, valid in the same cycle |
| memWrEn | output | 1 | Word write strobe |
| memWrAddr | output | ADDR_W | Byte address of the word written |
| memWrData | output | 32 | Word written |
| runOut | output | NCH | Per-channel run state |
| pendOut | output | NCH | Per-channel reload-pending state |
| doneOut | output | NCH | Sticky completion flags |
| errOut | output | NCH | Sticky error flags |

## Verification
Properties checked on every cycle cover the following invariants. Pending is never set without run. A reload keeps the channel running with pending cleared. Completion and error only rise on a channel that was running, and an error always leaves pending clear. A burst never exceeds its length or the burst limit. The scheduler performs at most one action per cycle, and memory writes happen only for a running channel. The bench scenarios cover what needs whole transfers to observe: correct data in both queued regions, burst length limits, alternation between busy channels, the effects of halt, failure and miss arming, sticky clearing, and randomly sized back-to-back queued transfers.

// File: rtl/dma_db_pkg.sv
package dma_db_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W = 8 * WORD_BYTES;

  // register select codes
  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // control register bit positions
  localparam int CTL_GO       = 0;
  localparam int CTL_HALT     = 1;
  localparam int CTL_MISS     = 2;
  localparam int CTL_FAIL     = 3;
  localparam int CTL_CLR_DONE = 4;
  localparam int CTL_CLR_ERR  = 5;

  // engine strobes from scheduler to datapath
  typedef struct packed {
    logic doFail;
    logic doFinish;
    logic doWord;
    logic doBurstEnd;
  } dmaStb_t;
endpackage

// File: rtl/dma_db_ctrl.sv
module dma_db_ctrl import dma_db_pkg::*; #(
  parameter int NCH = 4,
  parameter int CNT_W = 13,
  parameter int BURST_BYTES = 2048,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   chRun,
  input  logic [NCH-1:0]   chFail,
  input  logic [CNT_W-1:0] selCnt,
  output dmaStb_t          stb,
  output logic [CH_W-1:0]  svcCh,
  output logic [CNT_W-1:0] byteOff,
  output logic [CNT_W-1:0] burstBytes
);
  typedef enum logic {ST_PICK, ST_MOVE} slotState_t;

  localparam logic [CNT_W-1:0] BURST_LIM = CNT_W'(BURST_BYTES);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(WORD_BYTES);

  slotState_t state;
  logic [CH_W-1:0] chPtr, ptrNext;
  logic [CNT_W-1:0] off, lenR, burstLen;
  logic lastWord, startBurst;

  assign ptrNext = (chPtr == CH_W'(NCH - 1)) ? '0 : chPtr + 1'b1;
  assign burstLen = (selCnt > BURST_LIM) ? BURST_LIM : selCnt;
  assign lastWord = (off + STEP == lenR);
  assign startBurst = chRun[chPtr] && !chFail[chPtr] && (selCnt != '0);

  assign svcCh = chPtr;
  assign byteOff = off;
  assign burstBytes = lenR;

  always_comb begin
    stb = '0;
    if (state == ST_PICK) begin
      if (chRun[chPtr]) begin
        if (chFail[chPtr]) stb.doFail = 1'b1;
        else if (selCnt == '0) stb.doFinish = 1'b1;
      end
    end else if (chRun[chPtr]) begin
      stb.doWord = 1'b1;
      stb.doBurstEnd = lastWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_PICK;
      chPtr <= '0;
      off <= '0;
      lenR <= '0;
    end else begin
      case (state)
        ST_PICK: begin
          if (startBurst) begin
            state <= ST_MOVE;
            off <= '0;
            lenR <= burstLen;
          end else begin
            chPtr <= ptrNext;
          end
        end
        default: begin
          if (!chRun[chPtr] || lastWord) begin
            state <= ST_PICK;
            chPtr <= ptrNext;
          end else begin
            off <= off + STEP;
          end
        end
      endcase
    end
  end

  // burst window stays inside its length and the burst limit
  assert_burst_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MOVE) |-> (lenR != '0 && lenR <= BURST_LIM && off < lenR));

  // one engine action per cycle
  assert_single_action_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.doFail, stb.doFinish, stb.doWord}));

  // a finished burst hands the slot on to another channel
  assert_slot_moves_on_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.doBurstEnd |=> (state == ST_PICK && (NCH == 1 || chPtr != $past(chPtr))));
endmodule

// File: rtl/dma_db_datapath.sv
module dma_db_datapath import dma_db_pkg::*; #(
  parameter int NCH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W = 13,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  dmaStb_t           stb,
  input  logic [CH_W-1:0]   svcCh,
  input  logic [CNT_W-1:0]  byteOff,
  input  logic [CNT_W-1:0]  burstBytes,
  output logic [NCH-1:0]    chRun,
  output logic [NCH-1:0]    chFail,
  output logic [CNT_W-1:0]  selCnt,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [NCH-1:0]    pendOut,
  output logic [NCH-1:0]    doneOut,
  output logic [NCH-1:0]    errOut
);
  logic [ADDR_W-1:0] prgSrc [NCH], prgDst [NCH], actSrc [NCH], actDst [NCH];
  logic [ADDR_W-1:0] nPrgSrc[NCH], nPrgDst[NCH], nActSrc[NCH], nActDst[NCH];
  logic [CNT_W-1:0]  prgCnt [NCH], actCnt [NCH], nPrgCnt[NCH], nActCnt[NCH];
  logic [NCH-1:0] runR, pendR, doneR, errR, failArm, missArm;
  logic [NCH-1:0] nRun, nPend, nDone, nErr, nFail, nMiss;
  logic [ADDR_W-1:0] cfgAddr;
  logic [CNT_W-1:0] cfgCnt;

  assign cfgAddr = {cfgData[ADDR_W-1:2], 2'b00};
  assign cfgCnt = {cfgData[CNT_W-1:2], 2'b00};

  always_comb begin
    nPrgSrc = prgSrc; nPrgDst = prgDst; nPrgCnt = prgCnt;
    nActSrc = actSrc; nActDst = actDst; nActCnt = actCnt;
    nRun = runR; nPend = pendR; nDone = doneR; nErr = errR;
    nFail = failArm; nMiss = missArm;
    for (int i = 0; i < NCH; i++) begin
      // sticky clears first so a same-cycle set wins
      if (cfgWe && cfgCh == CH_W'(i) && cfgSel == SEL_CTRL) begin
        if (cfgData[CTL_CLR_DONE]) nDone[i] = 1'b0;
        if (cfgData[CTL_CLR_ERR]) nErr[i] = 1'b0;
      end
      // engine actions
      if (svcCh == CH_W'(i)) begin
        if (stb.doFail) begin
          nRun[i] = 1'b0; nPend[i] = 1'b0; nErr[i] = 1'b1; nFail[i] = 1'b0;
        end
        if (stb.doFinish) begin
          if (pendR[i]) begin
            nActSrc[i] = prgSrc[i]; nActDst[i] = prgDst[i]; nActCnt[i] = prgCnt[i];
            nPend[i] = 1'b0;
          end else begin
            nRun[i] = 1'b0;
            if (missArm[i]) nMiss[i] = 1'b0;
            else nDone[i] = 1'b1;
          end
        end
        if (stb.doBurstEnd) begin
          nActCnt[i] = actCnt[i] - burstBytes;
          nActSrc[i] = actSrc[i] + ADDR_W'(burstBytes);
          nActDst[i] = actDst[i] + ADDR_W'(burstBytes);
        end
      end
      // host actions apply to the post-engine state
      if (cfgWe && cfgCh == CH_W'(i)) begin
        case (cfgSel)
          SEL_SRC: nPrgSrc[i] = cfgAddr;
          SEL_DST: nPrgDst[i] = cfgAddr;
          SEL_CNT: nPrgCnt[i] = cfgCnt;
          default: begin
            if (cfgData[CTL_HALT]) begin
              nRun[i] = 1'b0; nPend[i] = 1'b0;
            end else if (cfgData[CTL_GO]) begin
              if (nRun[i]) nPend[i] = 1'b1;
              else begin
                nActSrc[i] = prgSrc[i]; nActDst[i] = prgDst[i]; nActCnt[i] = prgCnt[i];
                nRun[i] = 1'b1;
              end
            end
            if (cfgData[CTL_MISS] && !nRun[i]) nMiss[i] = 1'b1;
            if (cfgData[CTL_FAIL]) nFail[i] = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        prgSrc[i] <= '0; prgDst[i] <= '0; prgCnt[i] <= '0;
        actSrc[i] <= '0; actDst[i] <= '0; actCnt[i] <= '0;
      end
      runR <= '0; pendR <= '0; doneR <= '0; errR <= '0;
      failArm <= '0; missArm <= '0;
    end else begin
      prgSrc <= nPrgSrc; prgDst <= nPrgDst; prgCnt <= nPrgCnt;
      actSrc <= nActSrc; actDst <= nActDst; actCnt <= nActCnt;
      runR <= nRun; pendR <= nPend; doneR <= nDone; errR <= nErr;
      failArm <= nFail; missArm <= nMiss;
    end
  end

  assign chRun = runR;
  assign chFail = failArm;
  assign selCnt = actCnt[svcCh];
  assign memRdAddr = actSrc[svcCh] + ADDR_W'(byteOff);
  assign memWrAddr = actDst[svcCh] + ADDR_W'(byteOff);
  assign memWrEn = stb.doWord;
  assign memWrData = memRdData;
  assign pendOut = pendR;
  assign doneOut = doneR;
  assign errOut = errR;

  // memory is only written on behalf of a running channel
  assert_write_needs_run_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> runR[svcCh]);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic hostCtl;
    assign hostCtl = cfgWe && cfgCh == CH_W'(g) && cfgSel == SEL_CTRL;

    assert_pend_has_run_R3: assert property (@(posedge clk) disable iff (!rstN)
      pendR[g] |-> runR[g]);

    assert_reload_keeps_run_R4: assert property (@(posedge clk) disable iff (!rstN)
      (stb.doFinish && svcCh == CH_W'(g) && pendR[g] && !hostCtl) |=> (runR[g] && !pendR[g]));

    assert_done_from_run_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneR[g]) |-> $past(runR[g]));

    assert_err_halts_R9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errR[g]) |-> ($past(runR[g]) && !pendR[g]));
  end
endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine import dma_db_pkg::*; #(
  parameter int NCH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W = 13,
  parameter int BURST_BYTES = 2048,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [NCH-1:0]    runOut,
  output logic [NCH-1:0]    pendOut,
  output logic [NCH-1:0]    doneOut,
  output logic [NCH-1:0]    errOut
);
  dmaStb_t stb;
  logic [CH_W-1:0] svcCh;
  logic [CNT_W-1:0] byteOff, burstBytes, selCnt;
  logic [NCH-1:0] chRun, chFail;

  dma_db_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chRun(chRun), .chFail(chFail), .selCnt(selCnt),
    .stb(stb), .svcCh(svcCh), .byteOff(byteOff), .burstBytes(burstBytes)
  );

  dma_db_datapath #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgData(cfgData), .stb(stb), .svcCh(svcCh), .byteOff(byteOff),
    .burstBytes(burstBytes), .chRun(chRun), .chFail(chFail), .selCnt(selCnt),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .pendOut(pendOut),
    .doneOut(doneOut), .errOut(errOut)
  );

  assign runOut = chRun;
endmodule

// File: tb/tb_dbuf_dma_engine.sv
`timescale 1ns/1ps
module tb_dbuf_dma_engine;
  localparam int NCH = 4;
  localparam int ADDR_W = 16;
  localparam int MEM_WORDS = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgCh = '0;
  logic [1:0] cfgSel = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic [31:0] memRdData, memWrData;
  logic memWrEn;
  logic [NCH-1:0] runOut, pendOut, doneOut, errOut;

  logic [31:0] mem [MEM_WORDS];
  int checks = 0;
  int fails = 0;
  int wrTotal = 0;
  int curRun = 0;
  int maxRun = 0;
  int nOwn = 0;
  int owners [16];

  always #2.5 clk = ~clk;

  dbuf_dma_engine dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgData(cfgData), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .runOut(runOut), .pendOut(pendOut), .doneOut(doneOut), .errOut(errOut)
  );

  assign memRdData = mem[memRdAddr[ADDR_W-1:2]];

  // memory model and burst monitor
  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memWrAddr[ADDR_W-1:2]] <= memWrData;
      wrTotal++;
      if (curRun == 0 && nOwn < 16) begin
        owners[nOwn] = int'(memWrAddr[14]);
        nOwn++;
      end
      curRun++;
    end else if (curRun != 0) begin
      if (curRun > maxRun) maxRun = curRun;
      curRun = 0;
    end
  end

  function automatic logic [31:0] pat(int w);
    return (w * 32'h9E3779B1) ^ 32'hA5A50000;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(int ch, logic [1:0] sel, int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgCh = ch[1:0]; cfgSel = sel; cfgData = data[ADDR_W-1:0];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic prog(int ch, int src, int dst, int cnt);
    wrReg(ch, 2'd0, src);
    wrReg(ch, 2'd1, dst);
    wrReg(ch, 2'd2, cnt);
  endtask

  task automatic ctl(int ch, int bits);
    wrReg(ch, 2'd3, bits);
  endtask

  task automatic waitIdle(int ch, string req);
    for (int k = 0; k < 20000; k++) begin
      if (!runOut[ch]) return;
      @(negedge clk);
    end
    check(1'b0, req, "channel never went idle", 1, 0);
  endtask

  task automatic clearDst();
    for (int w = MEM_WORDS / 2; w < MEM_WORDS; w++) mem[w] = 32'h0;
  endtask

  task automatic checkMem(int src, int dst, int cnt, string req);
    int bad = -1;
    for (int k = 0; k < cnt / 4; k++) begin
      if (bad < 0 && mem[dst / 4 + k] != pat(src / 4 + k)) bad = k;
    end
    if (bad < 0) check(1'b1, req, "data", 0, 0);
    else check(1'b0, req, "data word", int'(mem[dst / 4 + bad]), int'(pat(src / 4 + bad)));
  endtask

  task automatic resetMon();
    maxRun = 0; nOwn = 0;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    int snap;
    int sSrc [NCH][2];
    int sDst [NCH][2];
    int sCnt [NCH][2];
    seed = $urandom(32'd2024);
    for (int w = 0; w < MEM_WORDS; w++) mem[w] = pat(w);
    clearDst();
    repeat (4) @(negedge clk);
    check(runOut == 0 && pendOut == 0, "R1", "run/pend after reset", int'({runOut, pendOut}), 0);
    check(doneOut == 0 && errOut == 0 && !memWrEn, "R1", "done/err/wr after reset",
          int'({doneOut, errOut, memWrEn}), 0);
    rstN = 1'b1;

    // R2/R3/R4/R5/R7: queued pair on channel 0
    resetMon();
    prog(0, 32'h0000, 32'h8000, 32'h1000);
    ctl(0, 1 << 0);
    check(runOut[0] && !pendOut[0], "R2", "start on idle", int'({runOut[0], pendOut[0]}), 2);
    prog(0, 32'h1000, 32'h9000, 32'h0202); // low bits ignored (R12)
    ctl(0, 1 << 0);
    check(runOut[0] && pendOut[0], "R3", "start on running", int'({runOut[0], pendOut[0]}), 3);
    for (int k = 0; k < 20000 && pendOut[0]; k++) @(negedge clk);
    check(runOut[0] && !doneOut[0], "R4", "reload keeps run, no completion",
          int'({runOut[0], doneOut[0]}), 2);
    waitIdle(0, "R5");
    check(doneOut[0], "R5", "completion after last", int'(doneOut[0]), 1);
    checkMem(32'h0000, 32'h8000, 32'h1000, "R3");
    checkMem(32'h1000, 32'h9000, 32'h0200, "R4");
    check(mem[(32'h9000 + 32'h200) / 4] == 0, "R12", "count low bits ignored",
          int'(mem[(32'h9000 + 32'h200) / 4]), 0);
    repeat (3) @(negedge clk);
    check(maxRun == 512, "R7", "longest burst in words", maxRun, 512);

    // R11: sticky until cleared
    repeat (20) @(negedge clk);
    check(doneOut[0], "R11", "completion sticky", int'(doneOut[0]), 1);
    ctl(0, 1 << 4);
    check(!doneOut[0], "R11", "completion cleared", int'(doneOut[0]), 0);

    // R8: round robin between channels 0 and 2
    resetMon();
    prog(2, 32'h2000, 32'hC000, 32'h1800);
    prog(0, 32'h0000, 32'h8000, 32'h1800);
    ctl(0, 1 << 0);
    ctl(2, 1 << 0);
    waitIdle(0, "R8");
    waitIdle(2, "R8");
    repeat (3) @(negedge clk);
    check(nOwn == 6, "R8", "burst count", nOwn, 6);
    for (int k = 1; k < 6; k++)
      check(owners[k] != owners[k - 1], "R8", "alternating owner", owners[k], 1 - owners[k - 1]);
    checkMem(32'h2000, 32'hC000, 32'h1800, "R8");
    ctl(0, 1 << 4);
    ctl(2, 1 << 4);

    // R10: halt clears run and pending, no more writes
    prog(1, 32'h0000, 32'hA000, 32'h1800);
    ctl(1, 1 << 0);
    ctl(1, 1 << 0);
    repeat (50) @(negedge clk);
    ctl(1, (1 << 1) | (1 << 0));
    snap = wrTotal;
    check(!runOut[1] && !pendOut[1], "R10", "halt state", int'({runOut[1], pendOut[1]}), 0);
    repeat (2000) @(negedge clk);
    check(wrTotal == snap, "R10", "writes after halt", wrTotal - snap, 0);
    check(!doneOut[1], "R10", "no completion after halt", int'(doneOut[1]), 0);

    // R12: zero count completes with no writes
    prog(1, 32'h0000, 32'hA000, 0);
    snap = wrTotal;
    ctl(1, 1 << 0);
    waitIdle(1, "R12");
    check(doneOut[1] && wrTotal == snap, "R12", "zero count", int'({doneOut[1], 1'(wrTotal != snap)}), 2);
    ctl(1, 1 << 4);

    // R6: miss armed while idle swallows one completion
    prog(3, 32'h3000, 32'hE000, 32'h40);
    ctl(3, 1 << 2);
    ctl(3, 1 << 0);
    waitIdle(3, "R6");
    repeat (10) @(negedge clk);
    check(!doneOut[3], "R6", "completion suppressed", int'(doneOut[3]), 0);
    ctl(3, 1 << 0);
    waitIdle(3, "R6");
    repeat (10) @(negedge clk);
    check(doneOut[3], "R6", "only one suppressed", int'(doneOut[3]), 1);
    ctl(3, 1 << 4);
    prog(3, 32'h3000, 32'hE000, 32'h800);
    ctl(3, 1 << 0);
    ctl(3, 1 << 2);
    waitIdle(3, "R6");
    repeat (10) @(negedge clk);
    check(doneOut[3], "R6", "arming while running ignored", int'(doneOut[3]), 1);
    ctl(3, 1 << 4);

    // R9: armed failure takes precedence over the burst
    clearDst();
    prog(2, 32'h2000, 32'hC000, 32'h100);
    ctl(2, 1 << 3);
    snap = wrTotal;
    ctl(2, 1 << 0);
    waitIdle(2, "R9");
    repeat (10) @(negedge clk);
    check(errOut[2] && !doneOut[2], "R9", "error not done", int'({errOut[2], doneOut[2]}), 2);
    check(wrTotal == snap && mem[32'hC000 / 4] == 0, "R9", "no data moved", wrTotal - snap, 0);
    check(!pendOut[2], "R9", "pending clear", int'(pendOut[2]), 0);
    ctl(2, 1 << 5);
    check(!errOut[2], "R11", "error cleared", int'(errOut[2]), 0);
    ctl(2, 1 << 0);
    waitIdle(2, "R9");
    check(doneOut[2] && !errOut[2], "R9", "failure one-shot", int'({doneOut[2], errOut[2]}), 2);
    checkMem(32'h2000, 32'hC000, 32'h100, "R9");
    ctl(2, 1 << 4);

    // random queued pairs on all channels
    for (int round = 0; round < 3; round++) begin
      clearDst();
      for (int c = 0; c < NCH; c++) begin
        for (int q = 0; q < 2; q++) begin
          sSrc[c][q] = c * 32'h2000 + q * 32'h1000 + int'($urandom_range(0, 255)) * 4;
          sDst[c][q] = 32'h8000 + c * 32'h2000 + q * 32'h1000 + int'($urandom_range(0, 255)) * 4;
          sCnt[c][q] = (int'($urandom_range(0, 511)) + 16) * 4;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        prog(c, sSrc[c][0], sDst[c][0], sCnt[c][0]);
        ctl(c, 1 << 0);
        prog(c, sSrc[c][1], sDst[c][1], sCnt[c][1]);
        ctl(c, 1 << 0);
      end
      for (int c = 0; c < NCH; c++) begin
        waitIdle(c, "R4");
        check(doneOut[c] && !pendOut[c], "R5", "random pair completion",
              int'({doneOut[c], pendOut[c]}), 2);
        checkMem(sSrc[c][0], sDst[c][0], sCnt[c][0], "R7");
        checkMem(sSrc[c][1], sDst[c][1], sCnt[c][1], "R4");
        ctl(c, 1 << 4);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule